// File: doc/BRIEF.md
# Read-after-write interlock controller for a five-stage in-order pipeline

This block is the stall and bubble control of an in-order integer pipeline whose stages are fetch, decode with register read, execute, memory access and write-back. It holds one instruction word and one valid bit for each stage from decode onward. Each stage decodes its own word to learn which registers it reads and writes. A read-after-write check compares the registers that the instruction in decode reads against the destinations of the older instructions further down the pipeline.

When a conflict is found, the block holds the program counter and the decode slot. It sends an empty slot, which acts as a no-operation, into execute, while the older instructions keep draining. The register file writes in write-back and reads in decode in the same cycle. Without forwarding, a consumer directly behind its producer therefore waits two extra cycles in decode. It enters execute in the cycle after the producer's write-back.

A run-time mode input enables forwarding instead. The instruction entering execute then takes an operand from the result held by the instruction in the memory stage or by the instruction in write-back. Only a load followed directly by its consumer still costs one bubble. The block also gives the datapath its gated write enables and the operand-source selects for execute.

Top module: `ilk_ctrl`

## Requirements
- R1: With `rst_n` low at a rising edge, all four stage valid bits are 0 after that edge and `pc_hold` is 0. The pipeline restarts empty.
- R2: Register fields are decoded as follows: opcode in bits 6:0, destination in bits 11:7, first source in bits 19:15 and second source in bits 24:20. Opcode 0110011 reads both sources and writes. Opcodes 0010011, 0000011 (load) and 1100111 read the first source and write. Opcodes 0100011 (store) and 1100011 read both sources and write nothing. Opcodes 0110111, 0010111 and 1101111 only write. Every other opcode reads and writes nothing. `wb_rd` shows bits 11:7 of the write-back instruction.
- R3: Register 0 never causes a stall. A source field that the opcode does not read never causes a stall. An instruction that does not write never causes a stall.
- R4: With `bypass_en` low, `pc_hold` is high while the valid decode instruction reads a nonzero register written by a valid instruction in execute or memory. A consumer directly behind its producer stalls exactly 2 cycles. A consumer with one unrelated instruction between it and its producer stalls 1 cycle. For a producer, its consumer and one unrelated instruction, the write-backs span 5 cycles.
- R5: While `pc_hold` is high, the decode slot keeps its instruction and the fetch inputs are ignored. Execute receives an empty slot, and the instructions already in execute and memory advance. `ex_bubble` is high exactly when execute will hold an empty slot after the next edge.
- R6: `wb_rf_we` is high only for a valid write-back instruction that writes a nonzero register. `ma_mem_we` is high only for a valid store in the memory stage. Empty slots never write.
- R7: With `bypass_en` high, a consumer directly behind a non-load producer does not stall. While the consumer is in execute, its select is 1, meaning the result held by the memory-stage instruction. A consumer two behind gets select 2, meaning the value of the write-back instruction. Select 0 means the register file value, and it is the only value with `bypass_en` low.
- R8: With `bypass_en` high, a consumer directly behind a load stalls exactly 1 cycle and then enters execute with select 2.
- R9: When both older instructions write the register that the consumer reads, select 1 (the nearer producer) wins over select 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bypass_en | input | 1 | 1 = forward results to execute operands, 0 = stall until the register file holds the value |
| if_instr | input | INSTR_W | Instruction word from fetch |
| if_valid | input | 1 | Fetch word is real |
| pc_hold | output | 1 | Hold the program counter and the decode slot this cycle |
| ex_bubble | output | 1 | Execute receives an empty slot at the next edge |
| stage_valid | output | 4 | Slot valid bits: bit 0 decode, 1 execute, 2 memory, 3 write-back |
| ex_fwd_a | output | 2 | Source select for the first operand of the execute instruction |
| ex_fwd_b | output | 2 | Source select for the second operand of the execute instruction |
| wb_rf_we | output | 1 | Register file write enable from the write-back slot |
| wb_rd | output | 5 | Destination register of the write-back slot |
| ma_mem_we | output | 1 | Data memory write enable from the memory slot |

## Verification
The bench builds the block with the default 32-bit word and the write-through register file. This makes the two-cycle back-to-back stall and the single load-use bubble the cases to reach. It flips `bypass_en` at run time, so one instance covers both the stalling and the forwarding decisions, including mode changes while instructions are in flight. Register numbers are drawn from a pool of four, with register 0 included. This makes same-register conflicts, nearest-producer priority and register-0 or unused-field false matches frequent. The compare-with-write-back variant, selected by clearing `WRITE_THROUGH`, is elaborated but not driven by the stimulus.

// File: rtl/ilk_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the interlock controller.
// Assumes the fixed 32-bit field layout: opcode [6:0], dest [11:7],
// first source [19:15], second source [24:20].
package ilk_pkg;
    localparam int REG_AW = 5;

    localparam logic [6:0] OPC_ALU    = 7'b0110011;
    localparam logic [6:0] OPC_ALUI   = 7'b0010011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_UPPER  = 7'b0110111;
    localparam logic [6:0] OPC_PCREL  = 7'b0010111;
    localparam logic [6:0] OPC_JUMP   = 7'b1101111;
    localparam logic [6:0] OPC_JUMPR  = 7'b1100111;

    // Per-stage decode result; flags are already gated by the slot valid bit.
    typedef struct packed {
        logic              wr;
        logic              use1;
        logic              use2;
        logic              load;
        logic              store;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
    } dec_t;

    // Operand source for the instruction in execute.
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_MEM = 2'd1,
        FWD_WB  = 2'd2
    } fwd_t;
endpackage

// File: rtl/ilk_decode.sv
`timescale 1ns/1ps
// Register-usage decoder for one pipeline slot.
// Reports which source fields are read and whether a destination is written.
// Assumes INSTR_W >= 32. An invalid slot reports no reads and no writes.
module ilk_decode #(
    parameter int INSTR_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic               valid,
    output ilk_pkg::dec_t      dec
);
    import ilk_pkg::*;

    logic unused_bits;
    assign unused_bits = ^{instr[INSTR_W-1:25], instr[14:12]};

    // Classify the opcode and extract the register fields.
    always_comb begin
        dec       = '0;
        dec.rd    = instr[7  +: REG_AW];
        dec.rs1   = instr[15 +: REG_AW];
        dec.rs2   = instr[20 +: REG_AW];
        case (instr[6:0])
            OPC_ALU:    begin dec.wr = 1'b1; dec.use1 = 1'b1; dec.use2 = 1'b1; end
            OPC_ALUI,
            OPC_JUMPR:  begin dec.wr = 1'b1; dec.use1 = 1'b1; end
            OPC_LOAD:   begin dec.wr = 1'b1; dec.use1 = 1'b1; dec.load = 1'b1; end
            OPC_STORE:  begin dec.use1 = 1'b1; dec.use2 = 1'b1; dec.store = 1'b1; end
            OPC_BRANCH: begin dec.use1 = 1'b1; dec.use2 = 1'b1; end
            OPC_UPPER,
            OPC_PCREL,
            OPC_JUMP:   dec.wr = 1'b1;
            default:    ;
        endcase
        if (!valid) begin
            dec.wr    = 1'b0;
            dec.use1  = 1'b0;
            dec.use2  = 1'b0;
            dec.load  = 1'b0;
            dec.store = 1'b0;
        end
    end
endmodule

// File: rtl/ilk_hazard.sv
`timescale 1ns/1ps
// Read-after-write detection for the decode slot.
// Compares decode sources with the destinations of older slots and decides
// between stalling and forwarding. With WRITE_THROUGH set, the register file
// returns a same-cycle write, so the write-back slot never conflicts.
module ilk_hazard #(
    parameter bit WRITE_THROUGH = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bypass_en,
    input  ilk_pkg::dec_t d_id,
    input  ilk_pkg::dec_t d_ex,
    input  ilk_pkg::dec_t d_ma,
    input  ilk_pkg::dec_t d_wb,
    output logic          stall,
    output ilk_pkg::fwd_t fwd_a,
    output ilk_pkg::fwd_t fwd_b
);
    import ilk_pkg::*;

    // True when a read source matches a nonzero written destination.
    function automatic logic hit(input logic used, input logic [REG_AW-1:0] src,
                                 input dec_t prod);
        return used && prod.wr && (prod.rd != '0) && (prod.rd == src);
    endfunction

    logic a_ex, b_ex, a_ma, b_ma, wb_conf;
    logic unused_fields;

    assign a_ex = hit(d_id.use1, d_id.rs1, d_ex);
    assign b_ex = hit(d_id.use2, d_id.rs2, d_ex);
    assign a_ma = hit(d_id.use1, d_id.rs1, d_ma);
    assign b_ma = hit(d_id.use2, d_id.rs2, d_ma);
    assign unused_fields = ^{d_id, d_ex, d_ma};

    // The register file variant picks whether write-back can conflict.
    generate
        if (WRITE_THROUGH) begin : g_wt
            logic unused_wb;
            assign unused_wb = ^d_wb;
            assign wb_conf   = 1'b0;
        end else begin : g_nwt
            assign wb_conf = hit(d_id.use1, d_id.rs1, d_wb) ||
                             hit(d_id.use2, d_id.rs2, d_wb);
        end
    endgenerate

    // Choose stall and operand sources for the current mode.
    always_comb begin
        fwd_a = FWD_RF;
        fwd_b = FWD_RF;
        if (bypass_en) begin
            stall = ((a_ex || b_ex) && d_ex.load) || wb_conf;
            if (a_ex)      fwd_a = FWD_MEM;
            else if (a_ma) fwd_a = FWD_WB;
            if (b_ex)      fwd_b = FWD_MEM;
            else if (b_ma) fwd_b = FWD_WB;
        end else begin
            stall = a_ex || b_ex || a_ma || b_ma || wb_conf;
        end
    end

    // A stall always has a real nonzero source behind it (R3).
    assert_stall_has_reader_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ((d_id.use1 && d_id.rs1 != '0) || (d_id.use2 && d_id.rs2 != '0)));

    // Forwarding hides every non-load conflict (R7).
    assert_bypass_no_alu_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_en && !d_ex.load && !wb_conf) |-> !stall);
endmodule

// File: rtl/ilk_stages.sv
`timescale 1ns/1ps
// Slot registers for decode, execute, memory and write-back.
// Each slot holds an instruction word and a valid bit. The execute slot also
// holds its operand selects. On stall the decode slot holds and execute
// receives an empty slot. Reset clears every valid bit.
module ilk_stages #(
    parameter int INSTR_W = 32,
    parameter int NSTG    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] if_instr,
    input  logic               if_valid,
    input  logic               stall,
    input  ilk_pkg::fwd_t      fwd_a_n,
    input  ilk_pkg::fwd_t      fwd_b_n,
    output logic [INSTR_W-1:0] instr_q [NSTG],
    output logic [NSTG-1:0]    valid_q,
    output ilk_pkg::fwd_t      fwd_a_q,
    output ilk_pkg::fwd_t      fwd_b_q
);
    import ilk_pkg::*;

    // Decode slot: load from fetch unless held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q[0] <= 1'b0;
            instr_q[0] <= '0;
        end else if (!stall) begin
            valid_q[0] <= if_valid;
            instr_q[0] <= if_instr;
        end
    end

    // Older slots shift every cycle; execute takes an empty slot on stall.
    generate
        for (genvar s = 1; s < NSTG; s++) begin : g_slot
            if (s == 1) begin : g_ex
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        valid_q[s] <= 1'b0;
                        instr_q[s] <= '0;
                    end else begin
                        valid_q[s] <= valid_q[s-1] && !stall;
                        instr_q[s] <= instr_q[s-1];
                    end
                end
            end else begin : g_old
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        valid_q[s] <= 1'b0;
                        instr_q[s] <= '0;
                    end else begin
                        valid_q[s] <= valid_q[s-1];
                        instr_q[s] <= instr_q[s-1];
                    end
                end
            end
        end
    endgenerate

    // Operand selects travel with the instruction into execute.
    always_ff @(posedge clk) begin
        if (!rst_n || stall || !valid_q[0]) begin
            fwd_a_q <= FWD_RF;
            fwd_b_q <= FWD_RF;
        end else begin
            fwd_a_q <= fwd_a_n;
            fwd_b_q <= fwd_b_n;
        end
    end

    // Reset empties the pipeline (R1).
    assert_empty_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

    // A held decode slot keeps its word and valid bit (R5).
    assert_id_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(instr_q[0]) && valid_q[0] == $past(valid_q[0])));

    // A stall puts an empty slot into execute (R5).
    assert_bubble_sent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !valid_q[1]);

    // A forward select never rides on an empty slot (R7).
    assert_fwd_on_real_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_q != FWD_RF || fwd_b_q != FWD_RF) |-> valid_q[1]);
endmodule

// File: rtl/ilk_ctrl.sv
`timescale 1ns/1ps
// Top of the read-after-write interlock controller.
// Holds the per-stage slots, decodes each slot separately, detects conflicts
// for the decode slot and drives stall, bubble, forward selects and gated
// write enables. Assumes the fetch side honours pc_hold by re-presenting
// the same word; the block ignores the fetch inputs while holding.
module ilk_ctrl #(
    parameter int INSTR_W       = 32,
    parameter bit WRITE_THROUGH = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bypass_en,
    input  logic [INSTR_W-1:0] if_instr,
    input  logic               if_valid,
    output logic               pc_hold,
    output logic               ex_bubble,
    output logic [3:0]         stage_valid,
    output logic [1:0]         ex_fwd_a,
    output logic [1:0]         ex_fwd_b,
    output logic               wb_rf_we,
    output logic [4:0]         wb_rd,
    output logic               ma_mem_we
);
    import ilk_pkg::*;

    localparam int NSTG = 4;
    localparam int S_ID = 0;
    localparam int S_EX = 1;
    localparam int S_MA = 2;
    localparam int S_WB = 3;

    logic [INSTR_W-1:0] instr_q [NSTG];
    logic [NSTG-1:0]    valid_q;
    dec_t               dec [NSTG];
    logic               stall;
    fwd_t               fwd_a_n, fwd_b_n, fwd_a_q, fwd_b_q;

    ilk_stages #(.INSTR_W(INSTR_W), .NSTG(NSTG)) u_stages (
        .clk      (clk),
        .rst_n    (rst_n),
        .if_instr (if_instr),
        .if_valid (if_valid),
        .stall    (stall),
        .fwd_a_n  (fwd_a_n),
        .fwd_b_n  (fwd_b_n),
        .instr_q  (instr_q),
        .valid_q  (valid_q),
        .fwd_a_q  (fwd_a_q),
        .fwd_b_q  (fwd_b_q)
    );

    // One decoder per slot: each stage decodes its own word.
    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_dec
            ilk_decode #(.INSTR_W(INSTR_W)) u_dec (
                .instr (instr_q[s]),
                .valid (valid_q[s]),
                .dec   (dec[s])
            );
        end
    endgenerate

    ilk_hazard #(.WRITE_THROUGH(WRITE_THROUGH)) u_hazard (
        .clk       (clk),
        .rst_n     (rst_n),
        .bypass_en (bypass_en),
        .d_id      (dec[S_ID]),
        .d_ex      (dec[S_EX]),
        .d_ma      (dec[S_MA]),
        .d_wb      (dec[S_WB]),
        .stall     (stall),
        .fwd_a     (fwd_a_n),
        .fwd_b     (fwd_b_n)
    );

    // Drive the block outputs from the slots and the conflict decision.
    always_comb begin
        pc_hold     = stall;
        ex_bubble   = !(valid_q[S_ID] && !stall);
        stage_valid = valid_q;
        ex_fwd_a    = fwd_a_q;
        ex_fwd_b    = fwd_b_q;
        wb_rd       = dec[S_WB].rd;
        wb_rf_we    = dec[S_WB].wr && (dec[S_WB].rd != '0);
        ma_mem_we   = dec[S_MA].store;
    end

    // Register writes come only from real slots with a nonzero target (R6).
    assert_wb_write_real_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_rf_we |-> (stage_valid[S_WB] && wb_rd != '0));

    // Memory writes come only from real slots (R6).
    assert_store_real_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ma_mem_we |-> stage_valid[S_MA]);

    // Older instructions keep moving while decode is held (R5).
    assert_older_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_hold && stage_valid[S_EX]) |=> stage_valid[S_MA]);

    // The bubble flag predicts the next execute slot (R5).
    assert_bubble_predicts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ex_bubble |=> !stage_valid[S_EX]);
endmodule

// File: tb/ilk_ctrl_tb.sv
`timescale 1ns/1ps
// Self-checking bench: reference pipeline model, seeded random traffic and
// directed stall-count cases.
module ilk_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bypass_en = 1'b0;
    logic [31:0] if_instr = '0;
    logic        if_valid = 1'b0;
    logic        pc_hold, ex_bubble, wb_rf_we, ma_mem_we;
    logic [3:0]  stage_valid;
    logic [1:0]  ex_fwd_a, ex_fwd_b;
    logic [4:0]  wb_rd;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    ilk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en),
        .if_instr(if_instr), .if_valid(if_valid),
        .pc_hold(pc_hold), .ex_bubble(ex_bubble), .stage_valid(stage_valid),
        .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b),
        .wb_rf_we(wb_rf_we), .wb_rd(wb_rd), .ma_mem_we(ma_mem_we)
    );

    localparam logic [6:0] OP_ALU = 7'b0110011, OP_ALUI = 7'b0010011,
                           OP_LD  = 7'b0000011, OP_ST   = 7'b0100011,
                           OP_BR  = 7'b1100011, OP_UP   = 7'b0110111,
                           OP_PCR = 7'b0010111, OP_J    = 7'b1101111,
                           OP_JR  = 7'b1100111;

    // Reference model state: slot 0 decode .. 3 write-back.
    logic [31:0] mi [4];
    logic        mv [4];
    logic [1:0]  mfa, mfb;

    int n_stall, cyc, first_wb, last_wb;
    logic [1:0] last_fwd;
    logic [31:0] prog [8];

    function automatic logic [31:0] mk(input logic [6:0] op, input logic [4:0] rd,
                                       input logic [4:0] s1, input logic [4:0] s2);
        return {7'd0, s2, s1, 3'd0, rd, op};
    endfunction

    // {writes, reads first, reads second} per R2.
    function automatic logic [2:0] f_use(input logic [31:0] i);
        case (i[6:0])
            OP_ALU:             return 3'b111;
            OP_ALUI, OP_LD, OP_JR: return 3'b110;
            OP_ST, OP_BR:       return 3'b011;
            OP_UP, OP_PCR, OP_J: return 3'b100;
            default:            return 3'b000;
        endcase
    endfunction

    function automatic logic m_hit(input logic used, input logic [4:0] src, input int s);
        return used && mv[s] && f_use(mi[s])[2] && (mi[s][11:7] != 5'd0) &&
               (mi[s][11:7] == src);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, compare with the model, advance it.
    task automatic step(input logic [31:0] ins, input logic v);
        logic u1, u2, ae, be, am, bm, est, ebub, ewb, emw;
        logic [1:0] efa, efb;
        if_instr = ins;
        if_valid = v;
        #1;
        u1 = mv[0] && f_use(mi[0])[1];
        u2 = mv[0] && f_use(mi[0])[0];
        ae = m_hit(u1, mi[0][19:15], 1);
        be = m_hit(u2, mi[0][24:20], 1);
        am = m_hit(u1, mi[0][19:15], 2);
        bm = m_hit(u2, mi[0][24:20], 2);
        efa = 2'd0;
        efb = 2'd0;
        if (bypass_en) begin
            est = (ae || be) && (mi[1][6:0] == OP_LD);
            efa = ae ? 2'd1 : (am ? 2'd2 : 2'd0);   // R9 priority: nearer first
            efb = be ? 2'd1 : (bm ? 2'd2 : 2'd0);
        end else begin
            est = ae || be || am || bm;
        end
        ebub = !(mv[0] && !est);
        ewb  = mv[3] && f_use(mi[3])[2] && (mi[3][11:7] != 5'd0);
        emw  = mv[2] && (mi[2][6:0] == OP_ST);
        if (rst_n) begin
            chk(pc_hold === est, "R4", "pc_hold", int'(pc_hold), int'(est));
            chk(ex_bubble === ebub, "R5", "ex_bubble", int'(ex_bubble), int'(ebub));
            chk(stage_valid === {mv[3], mv[2], mv[1], mv[0]}, "R5", "stage_valid",
                int'(stage_valid), int'({mv[3], mv[2], mv[1], mv[0]}));
            chk(ex_fwd_a === mfa, "R7", "ex_fwd_a", int'(ex_fwd_a), int'(mfa));
            chk(ex_fwd_b === mfb, "R7", "ex_fwd_b", int'(ex_fwd_b), int'(mfb));
            chk(wb_rf_we === ewb, "R6", "wb_rf_we", int'(wb_rf_we), int'(ewb));
            chk(ma_mem_we === emw, "R6", "ma_mem_we", int'(ma_mem_we), int'(emw));
            if (mv[3]) chk(wb_rd === mi[3][11:7], "R2", "wb_rd", int'(wb_rd), int'(mi[3][11:7]));
            if (pc_hold) n_stall++;
            if (stage_valid[3]) begin
                if (first_wb < 0) first_wb = cyc;
                last_wb = cyc;
            end
            if (ex_fwd_a != 2'd0) last_fwd = ex_fwd_a;
        end
        cyc++;
        if (!rst_n) begin
            for (int s = 0; s < 4; s++) mv[s] = 1'b0;
            mfa = 2'd0;
            mfb = 2'd0;
        end else begin
            mi[3] = mi[2]; mv[3] = mv[2];
            mi[2] = mi[1]; mv[2] = mv[1];
            mi[1] = mi[0]; mv[1] = mv[0] && !est;
            mfa = (est || !mv[0]) ? 2'd0 : efa;
            mfb = (est || !mv[0]) ? 2'd0 : efb;
            if (!est) begin
                mi[0] = ins;
                mv[0] = v;
            end
        end
        @(negedge clk);
    endtask

    // Feed prog[0..n-1] obeying pc_hold, then drain; counts stalls and write-backs.
    task automatic feed(input int n);
        int idx = 0;
        n_stall = 0;
        first_wb = -1;
        last_wb = -1;
        last_fwd = 2'd0;
        while (idx < n) begin
            logic hold;
            hold = pc_hold;
            step(prog[idx], 1'b1);
            if (!hold) idx++;
        end
        repeat (8) step(32'd0, 1'b0);
    endtask

    function automatic logic [31:0] rnd_instr();
        logic [6:0] ops [11] = '{OP_ALU, OP_ALUI, OP_LD, OP_ST, OP_BR, OP_UP,
                                 OP_PCR, OP_J, OP_JR, 7'b0000000, 7'b1110011};
        return mk(ops[$urandom_range(10)], 5'($urandom_range(3)),
                  5'($urandom_range(3)), 5'($urandom_range(3)));
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        for (int s = 0; s < 4; s++) begin mv[s] = 1'b0; mi[s] = '0; end
        mfa = 2'd0; mfb = 2'd0; cyc = 0; first_wb = -1; last_wb = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(stage_valid === 4'd0, "R1", "valid after reset", int'(stage_valid), 0);
        chk(pc_hold === 1'b0, "R1", "pc_hold after reset", int'(pc_hold), 0);
        @(negedge clk);

        // R4: back-to-back consumer stalls two cycles.
        bypass_en = 1'b0;
        prog[0] = mk(OP_ALU, 5'd1, 5'd2, 5'd3);
        prog[1] = mk(OP_ALU, 5'd2, 5'd1, 5'd0);
        feed(2);
        chk(n_stall == 2, "R4", "back-to-back stalls", n_stall, 2);

        // R4: one unrelated instruction between -> one stall.
        prog[0] = mk(OP_ALUI, 5'd1, 5'd2, 5'd0);
        prog[1] = mk(OP_ALUI, 5'd3, 5'd2, 5'd0);
        prog[2] = mk(OP_ST, 5'd0, 5'd2, 5'd1);
        feed(3);
        chk(n_stall == 1, "R4", "gap-one stalls", n_stall, 1);

        // R4: producer, consumer, unrelated -> write-backs span 5 cycles.
        prog[0] = mk(OP_ALU, 5'd1, 5'd2, 5'd3);
        prog[1] = mk(OP_ALU, 5'd4, 5'd1, 5'd1);
        prog[2] = mk(OP_ALUI, 5'd5, 5'd6, 5'd0);
        feed(3);
        chk(last_wb - first_wb + 1 == 5, "R4", "write-back span", last_wb - first_wb + 1, 5);

        // R3: destination register 0 does not stall.
        prog[0] = mk(OP_ALUI, 5'd0, 5'd2, 5'd0);
        prog[1] = mk(OP_ALU, 5'd3, 5'd0, 5'd0);
        feed(2);
        chk(n_stall == 0, "R3", "register 0 stalls", n_stall, 0);

        // R3: a store writes nothing even if bits 11:7 name the source.
        prog[0] = mk(OP_ST, 5'd1, 5'd2, 5'd3);
        prog[1] = mk(OP_ALU, 5'd4, 5'd1, 5'd1);
        feed(2);
        chk(n_stall == 0, "R3", "non-writer stalls", n_stall, 0);

        // R3: second-source field unused by an immediate op.
        prog[0] = mk(OP_ALU, 5'd1, 5'd2, 5'd3);
        prog[1] = mk(OP_ALUI, 5'd5, 5'd6, 5'd1);
        feed(2);
        chk(n_stall == 0, "R3", "unused field stalls", n_stall, 0);

        // R7: forwarding removes the back-to-back stall, select 1 seen.
        bypass_en = 1'b1;
        prog[0] = mk(OP_ALU, 5'd1, 5'd2, 5'd3);
        prog[1] = mk(OP_ALU, 5'd2, 5'd1, 5'd1);
        feed(2);
        chk(n_stall == 0, "R7", "bypass stalls", n_stall, 0);
        chk(last_fwd == 2'd1, "R7", "bypass select", int'(last_fwd), 1);

        // R7: consumer two behind takes select 2.
        prog[0] = mk(OP_ALU, 5'd1, 5'd2, 5'd3);
        prog[1] = mk(OP_ALUI, 5'd3, 5'd2, 5'd0);
        prog[2] = mk(OP_ALU, 5'd2, 5'd1, 5'd0);
        feed(3);
        chk(last_fwd == 2'd2, "R7", "gap-one select", int'(last_fwd), 2);

        // R8: load-use costs one bubble, then select 2.
        prog[0] = mk(OP_LD, 5'd1, 5'd2, 5'd0);
        prog[1] = mk(OP_ALU, 5'd2, 5'd1, 5'd0);
        feed(2);
        chk(n_stall == 1, "R8", "load-use stalls", n_stall, 1);
        chk(last_fwd == 2'd2, "R8", "load-use select", int'(last_fwd), 2);

        // R9: two writers of one register, nearer one wins.
        prog[0] = mk(OP_ALU, 5'd1, 5'd2, 5'd3);
        prog[1] = mk(OP_ALUI, 5'd1, 5'd1, 5'd0);
        prog[2] = mk(OP_ALU, 5'd3, 5'd1, 5'd0);
        feed(3);
        chk(last_fwd == 2'd1, "R9", "nearest select", int'(last_fwd), 1);

        // Random traffic, mode flips and one reset in flight (R1..R9 via model).
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) bypass_en = 1'($urandom_range(1));
            if (i == 2000) begin
                rst_n = 1'b0;
                step(rnd_instr(), 1'b1);
                rst_n = 1'b1;
                #1;
                chk(stage_valid === 4'd0, "R1", "valid after mid reset", int'(stage_valid), 0);
            end else begin
                step(rnd_instr(), ($urandom_range(9) < 8));
            end
        end
        repeat (8) step(32'd0, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule